// File: doc/BRIEF.md
# Speculative Receive Accumulator with Late-Fail Rollback

This block sits on the receive side of a clock-domain crossing whose data-available flag is produced early. The flag comes from a synchronizer that samples sooner than full reliability requires. The block captures the word the receive FIFO presents whenever that flag is high. It immediately forms a speculative running sum in a slave register, and it keeps a committed sum in a master register. The synchronizer raises a fail flag if the early sample later turns out to have been unsettled. That fail verdict for a capture arrives during the cycle that follows it.

In that following cycle the block settles the capture. With no fail, it drives read-done so that the FIFO read pointer steps before the next edge, and it folds the speculative sum into the master at that edge. With fail, read-done stays low and the master keeps its value. The FIFO then still points at the same entry, which is captured again one cycle later. Each failure therefore costs exactly one cycle, and every word enters the committed sum exactly once.

The slave can be built either as a register that holds the speculative sum or as an adder over the master and an input register. A parameter selects which one.

Top module: `spec_accum`

## Requirements
- R1: While reset is asserted, read-done is 0 and both the committed and the speculative sums read 0. After reset no capture is pending.
- R2: At each clock edge where data-available is high, the word is captured. After that edge the speculative sum equals the committed sum plus the zero-extended word. At an edge where data-available is low, the speculative sum after the edge equals the committed sum.
- R3: In the cycle after a capture, read-done is high exactly when fail is low. The output follows fail within that same cycle, so the FIFO pointer can step before the next edge.
- R4: A fail in the cycle after a capture leaves the committed sum unchanged at the following edge and keeps read-done low.
- R5: A capture that is not failed adds its word to the committed sum at the edge that ends the cycle in which read-done is high.
- R6: A fail raised in a cycle with no pending capture has no effect: read-done stays 0 and the committed sum is unchanged.
- R7: A failed word is presented again and captured in the next cycle. A stream of N words with F failed captures and no gaps completes in N+F capture cycles, and the committed sum grows by the sum of the N words, each counted once.
- R8: Read-done is never high in a cycle where fail is high.
- R9: Both sums wrap modulo 2^ACC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Word presented by the FIFO at its read pointer |
| in_avail | input | 1 | Early (speculative) data-available flag |
| in_fail | input | 1 | Late verdict: the capture of the previous cycle is invalid |
| rd_done | output | 1 | Read acknowledge; the FIFO read pointer steps on it |
| acc_commit | output | ACC_W | Committed (master) sum |
| acc_spec | output | ACC_W | Speculative (slave) sum including the pending word |

## Verification
The hard case is a fail that lands exactly in the cycle after a capture while the FIFO keeps streaming. The bench has to show both that the same word returns and that the pointer holds still. A fail on an idle cycle is the other such case, because it must stay invisible. The bench models the FIFO as an array whose presented entry already reflects read-done in the current cycle. It sweeps several fail patterns over full-rate and gapped streams: none, alternate cycles, every third cycle and a pseudo-random sequence. For each stream it checks per-cycle sums, the total sum and the total number of cycles taken.

// File: rtl/spec_accum_pkg.sv
package spec_accum_pkg;

   // Outcome of a pending speculative capture in the cycle its verdict arrives
   typedef enum logic [1:0] {
      VRD_IDLE   = 2'd0,
      VRD_COMMIT = 2'd1,
      VRD_RETRY  = 2'd2
   } verdict_e;

   function automatic verdict_e resolve(input logic pending, input logic late_fail);
      if (!pending)       return VRD_IDLE;
      else if (late_fail) return VRD_RETRY;
      else                return VRD_COMMIT;
   endfunction

endpackage

// File: rtl/spec_accum_capture.sv
module spec_accum_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              avail,
   input  logic [DATA_W-1:0] data,
   output logic              pend,
   output logic [DATA_W-1:0] item
);
   // Input register: overwritten on every speculative capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         item <= '0;
      end else begin
         pend <= avail;
         if (avail) item <= data;
      end
   end
endmodule

// File: rtl/spec_accum_verdict.sv
module spec_accum_verdict
   import spec_accum_pkg::*;
(
   input  logic pend,
   input  logic fail,
   output logic commit,
   output logic rd_done
);
   verdict_e vrd;

   always_comb begin
      vrd     = resolve(pend, fail);
      commit  = (vrd == VRD_COMMIT);
      rd_done = (vrd == VRD_COMMIT);
   end
endmodule

// File: rtl/spec_accum_ms.sv
module spec_accum_ms #(
   parameter int DATA_W    = 16,
   parameter int ACC_W     = 32,
   parameter bit SLAVE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              avail,
   input  logic [DATA_W-1:0] data,
   input  logic              pend,
   input  logic [DATA_W-1:0] item,
   output logic [ACC_W-1:0]  master,
   output logic [ACC_W-1:0]  slave
);
   localparam int PAD_W = ACC_W - DATA_W;

   logic [ACC_W-1:0] master_nxt;
   logic [ACC_W-1:0] data_x;
   logic [ACC_W-1:0] item_x;

   assign data_x = ACC_W'(data);
   assign item_x = ACC_W'(item);

   generate
      if (SLAVE_REG) begin : g_slave_reg
         // Slave holds master_nxt + captured word; commit copies it across
         logic [ACC_W-1:0] slave_q;

         always_comb master_nxt = commit ? slave_q : master;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               master  <= '0;
               slave_q <= '0;
            end else begin
               master  <= master_nxt;
               slave_q <= avail ? (master_nxt + data_x) : master_nxt;
            end
         end

         assign slave = slave_q;

         logic unused_ok;
         assign unused_ok = ^{pend, item_x, PAD_W[0]};
      end else begin : g_slave_comb
         // Slave computed from master and the input register
         always_comb master_nxt = commit ? (master + item_x) : master;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) master <= '0;
            else        master <= master_nxt;
         end

         assign slave = pend ? (master + item_x) : master;

         logic unused_ok;
         assign unused_ok = ^{avail, data_x, PAD_W[0]};
      end
   endgenerate
endmodule

// File: rtl/spec_accum.sv
module spec_accum #(
   parameter int DATA_W    = 16,
   parameter int ACC_W     = 32,
   parameter bit SLAVE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_avail,
   input  logic              in_fail,
   output logic              rd_done,
   output logic [ACC_W-1:0]  acc_commit,
   output logic [ACC_W-1:0]  acc_spec
);
   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("spec_accum: DATA_W must be at least 1");
      end
      if (ACC_W < DATA_W) begin : g_bad_aw
         $error("spec_accum: ACC_W must not be narrower than DATA_W");
      end
   endgenerate

   logic              pend;
   logic [DATA_W-1:0] item;
   logic              commit;

   spec_accum_capture #(.DATA_W(DATA_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .avail (in_avail),
      .data  (in_data),
      .pend  (pend),
      .item  (item)
   );

   spec_accum_verdict u_vrd (
      .pend    (pend),
      .fail    (in_fail),
      .commit  (commit),
      .rd_done (rd_done)
   );

   spec_accum_ms #(
      .DATA_W    (DATA_W),
      .ACC_W     (ACC_W),
      .SLAVE_REG (SLAVE_REG)
   ) u_ms (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .avail  (in_avail),
      .data   (in_data),
      .pend   (pend),
      .item   (item),
      .master (acc_commit),
      .slave  (acc_spec)
   );
endmodule

// File: rtl/spec_accum_chk.sv
module spec_accum_chk #(
   parameter int DATA_W    = 16,
   parameter int ACC_W     = 32,
   parameter bit SLAVE_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] in_data,
   input logic              in_avail,
   input logic              in_fail,
   input logic              rd_done,
   input logic [ACC_W-1:0]  acc_commit,
   input logic [ACC_W-1:0]  acc_spec
);
   logic unused_p;
   assign unused_p = SLAVE_REG;

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!rd_done && acc_commit == '0)); // R1
   AST_SPEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      in_avail |=> acc_spec == ACC_W'(acc_commit + ACC_W'($past(in_data)))); // R2
   AST_SPEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_avail |=> acc_spec == acc_commit); // R2
   AST_DONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(in_avail)); // R3
   AST_FAIL_KEEPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
      in_fail |=> acc_commit == $past(acc_commit)); // R4
   AST_COMMIT_TAKES_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> acc_commit == $past(acc_spec)); // R5
   AST_NO_DONE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_done |=> $stable(acc_commit)); // R6
   AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> !in_fail); // R8
endmodule

bind spec_accum spec_accum_chk #(
   .DATA_W    (DATA_W),
   .ACC_W     (ACC_W),
   .SLAVE_REG (SLAVE_REG)
) u_chk (.*);

// File: tb/tb_spec_accum.sv
module tb_spec_accum;
   localparam int DW   = 8;
   localparam int AW   = 10;
   localparam int MOD  = 1 << AW;
   localparam int MAXN = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [DW-1:0] in_data;
   logic          in_avail;
   logic          in_fail;
   logic          rd_done;
   logic [AW-1:0] acc_commit;
   logic [AW-1:0] acc_spec;

   always #10 clk = ~clk;

   spec_accum #(.DATA_W(DW), .ACC_W(AW)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_data    (in_data),
      .in_avail   (in_avail),
      .in_fail    (in_fail),
      .rd_done    (rd_done),
      .acc_commit (acc_commit),
      .acc_spec   (acc_spec)
   );

   // FIFO model: pointer steps on read-done; presented entry already looks past it
   int      mem [MAXN];
   int      ptr;
   int      nitems;
   logic    run_en;
   int      idx;

   always_comb begin
      idx      = ptr + (rd_done ? 1 : 0);
      in_avail = run_en && (idx < nitems);
      in_data  = (idx < MAXN) ? DW'(mem[idx]) : '0;
   end

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   int        exp_master = 0;
   int        exp_item   = 0;
   bit        exp_pend   = 1'b0;
   logic [15:0] lfsr     = 16'hACE1;

   task automatic run_phase(input int n, input int base, input int fmode, input bit gaps);
      int  start, sum, hits, dones, iters;
      bit  last_rd, f, prev_retry, prev_idle_fail;
      for (int i = 0; i < n; i++) mem[i] = (base + i * 37) % 256;
      sum = 0;
      for (int i = 0; i < n; i++) sum += mem[i];
      @(negedge clk);
      nitems = n; ptr = 0;
      start = exp_master; hits = 0; dones = 0; iters = 0;
      last_rd = 1'b0; prev_retry = 1'b0; prev_idle_fail = 1'b0;
      while ((ptr < n || exp_pend) && iters < 1000) begin
         if (iters != 0) @(negedge clk);
         if (last_rd) ptr++;
         case (fmode)
            1:       f = iters[0];
            2:       begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; f = lfsr[0]; end
            3:       f = (iters % 3 == 1);
            default: f = 1'b0;
         endcase
         run_en  = !(gaps && (iters % 4 == 3));
         in_fail = f;
         #1;
         chk("R3", int'(rd_done), int'(exp_pend && !f));
         if (f) chk("R8", int'(rd_done), 0);
         if (prev_retry)          chk("R4 master held", int'(acc_commit), exp_master);
         else if (prev_idle_fail) chk("R6 master held", int'(acc_commit), exp_master);
         else                     chk("R5", int'(acc_commit), exp_master);
         chk("R2", int'(acc_spec), exp_pend ? (exp_master + exp_item) % MOD : exp_master);
         prev_retry     = exp_pend && f;
         prev_idle_fail = !exp_pend && f;
         if (exp_pend && f) hits++;
         if (exp_pend && !f) begin
            exp_master = (exp_master + exp_item) % MOD;
            dones++;
         end
         last_rd  = rd_done;
         exp_pend = in_avail;
         exp_item = int'(in_data);
         iters++;
      end
      run_en = 1'b0;
      chk("R7 sum each once", int'(acc_commit), (start + sum) % MOD);
      chk("R7 acks", dones, n);
      if (!gaps) chk("R7 one cycle per fail", iters, n + hits + 2);
      chk("R9 wrap", int'(acc_commit), exp_master);
   endtask

   initial begin
      #4000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_fail = 1'b1; run_en = 1'b0; nitems = 0; ptr = 0;
      repeat (3) @(negedge clk);
      chk("R1 rd_done", int'(rd_done), 0);
      chk("R1 commit", int'(acc_commit), 0);
      chk("R1 spec", int'(acc_spec), 0);
      rst_n   = 1'b1;
      in_fail = 1'b0;
      @(negedge clk);
      chk("R1 no pending", int'(rd_done), 0);
      run_phase(20, 5,   0, 1'b0);
      run_phase(20, 250, 1, 1'b0);
      run_phase(40, 128, 2, 1'b0);
      run_phase(30, 200, 3, 1'b0);
      run_phase(30, 77,  2, 1'b1);
      run_phase(20, 255, 1, 1'b1);
      run_phase(40, 31,  3, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule